// File: doc/BRIEF.md
# Memory Renaming Predictor

This block works at the rename stage of an out-of-order core. It learns which store feeds which later load, the common case being a spill to the stack followed by a reload of the same slot. Once a store/load pair has proven itself often enough, a renamed load is not sent to memory. Instead, its destination physical register becomes an alias of the physical register that holds the store's data. The load then completes in the cycle it is renamed.

Each cycle, rename can present one store descriptor and one load descriptor. A descriptor carries the instruction pointer, a flag marking a stack-pointer-relative address, the offset, and, for a store, the data register tag. The load/store unit later reports what it found for a load: whether the load had been bypassed, and whether it really matched the named store. These reports train a 16-entry pair table. The table holds a 2-bit saturating confidence per entry and uses least-recently-trained replacement. An 8-entry buffer of recent stack stores supplies the producer tag.

A controller with two states runs the block:
- **ST_RUN** is normal operation.
- **ST_FLUSH** lasts one cycle after a misprediction is reported. In it the flush request is driven and the rename slot is treated as squashed.

The transitions are:
- RUN→RUN when no misprediction is reported.
- RUN→FLUSH on a reported misprediction.
- FLUSH→FLUSH when another misprediction arrives during the flush.
- FLUSH→RUN otherwise.

The bypass strobe also serves as the reference-count increment request for the aliased register.

Top module: `mem_rename_pred`

## Requirements
- R1: After reset the table and the store buffer are empty, no bypass is made and no flush is requested.
- R2: A stack-relative load makes a bypass in the same cycle when both of these hold. First, a table entry with the load's instruction pointer and offset has confidence 3. Second, the store buffer holds a stack store with that entry's store pointer and the same offset. byp_ptag is then the tag of the youngest such store, and byp_valid doubles as the reference-count increment request.
- R3: A load with ld_sp low never bypasses. A store with st_sp low is not recorded.
- R4: A report with vr_match high increments the confidence of the entry keyed by (store pointer, load pointer, offset), saturating at 3. If no such entry exists, one is allocated with confidence 1. Below confidence 3 no bypass is made.
- R5: A report with vr_bypassed high and vr_match low resets that entry's confidence to 0. It also raises flush_valid in the next cycle only, with flush_rob equal to the reported vr_rob. Consecutive such reports give consecutive flush cycles.
- R6: In a cycle where flush_valid is high, no load is bypassed and no store is recorded.
- R7: The store buffer keeps only the last 8 recorded stores. When the predicted store has been pushed out, the load is not bypassed.
- R8: When all 16 entries are valid, an allocation replaces the entry trained least recently. Every report that finds or allocates an entry counts as training it.
- R9: A store or a table update in the same cycle as a load is not visible to that load's prediction.
- R10: A report with both vr_bypassed and vr_match low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store descriptor present |
| st_sp | input | 1 | Store address is stack-pointer relative |
| st_ip | input | 16 | Store instruction pointer |
| st_off | input | 12 | Store offset (signed) |
| st_ptag | input | 7 | Physical register holding the store data |
| ld_valid | input | 1 | Load descriptor present |
| ld_sp | input | 1 | Load address is stack-pointer relative |
| ld_ip | input | 16 | Load instruction pointer |
| ld_off | input | 12 | Load offset (signed) |
| vr_valid | input | 1 | Verification report present |
| vr_bypassed | input | 1 | Reported load was bypassed |
| vr_match | input | 1 | Load really read the named store's address |
| vr_st_ip | input | 16 | Store pointer of the report |
| vr_ld_ip | input | 16 | Load pointer of the report |
| vr_off | input | 12 | Offset of the report |
| vr_rob | input | 6 | Reorder-buffer index of the reported load |
| byp_valid | output | 1 | Load is aliased this cycle; also the reference-count increment request |
| byp_ptag | output | 7 | Physical register the load is aliased to |
| flush_valid | output | 1 | Flush from the named load onward |
| flush_rob | output | 6 | Reorder-buffer index to flush from |

## Verification
The hardest situation to reach is replacement in a full table. The victim has to be decided by the training order, not the allocation order. Showing this requires the table to be filled with 16 distinct pairs and one old pair to be retrained before a 17th pair arrives. The bench then proves which pair was evicted by retraining it and watching whether a bypass appears one report earlier or later than it would if the pair had survived. Eviction from the store buffer is reached in a similar way: after the producer store, exactly 8 unrelated stack stores are pushed, and in a second run 7 are pushed to show the boundary.

// File: rtl/mrp_pkg.sv
package mrp_pkg;
    typedef enum logic {ST_RUN, ST_FLUSH} rn_state_e;
    typedef enum logic [1:0] {UPD_NONE, UPD_GOOD, UPD_BAD} upd_kind_e;
endpackage

// File: rtl/mrp_store_buf.sv
module mrp_store_buf
#(
    parameter int DEPTH  = 8,
    parameter int IP_W   = 16,
    parameter int OFF_W  = 12,
    parameter int PTAG_W = 7
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IP_W-1:0]   wr_ip,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [PTAG_W-1:0] wr_ptag,
    input  logic [IP_W-1:0]   q_ip,
    input  logic [OFF_W-1:0]  q_off,
    output logic              q_hit,
    output logic [PTAG_W-1:0] q_ptag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  slot_vld;
    logic [IP_W-1:0]   slot_ip   [DEPTH];
    logic [OFF_W-1:0]  slot_off  [DEPTH];
    logic [PTAG_W-1:0] slot_tag  [DEPTH];
    logic [PTR_W-1:0]  wptr;

    // youngest matching slot wins: scan oldest to youngest, later hits override
    always_comb begin
        q_hit  = 1'b0;
        q_ptag = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [PTR_W-1:0] idx;
            idx = PTR_W'((int'(wptr) + 2 * DEPTH - 1 - k) % DEPTH);
            if (slot_vld[idx] && slot_ip[idx] == q_ip && slot_off[idx] == q_off) begin
                q_hit  = 1'b1;
                q_ptag = slot_tag[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            wptr     <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_ip[i]  <= '0;
                slot_off[i] <= '0;
                slot_tag[i] <= '0;
            end
        end else if (wr_en) begin
            slot_vld[wptr] <= 1'b1;
            slot_ip[wptr]  <= wr_ip;
            slot_off[wptr] <= wr_off;
            slot_tag[wptr] <= wr_ptag;
            wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        end
    end

    AST_SB_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!(q_ip == $past(wr_ip) && q_off == $past(wr_off)) ||
                   (q_hit && q_ptag == $past(wr_ptag)))); // R2
endmodule

// File: rtl/mrp_pred_table.sv
module mrp_pred_table
    import mrp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IP_W    = 16,
    parameter int OFF_W   = 12,
    parameter int CONF_W  = 2
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IP_W-1:0]  lk_ld_ip,
    input  logic [OFF_W-1:0] lk_off,
    output logic             lk_hit,
    output logic [IP_W-1:0]  lk_st_ip,
    input  upd_kind_e        upd_kind,
    input  logic [IP_W-1:0]  upd_st_ip,
    input  logic [IP_W-1:0]  upd_ld_ip,
    input  logic [OFF_W-1:0] upd_off
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CONF_W-1:0] CONF_TOP = {CONF_W{1'b1}};

    logic [ENTRIES-1:0] vld;
    logic [IP_W-1:0]    e_sip  [ENTRIES];
    logic [IP_W-1:0]    e_lip  [ENTRIES];
    logic [OFF_W-1:0]   e_off  [ENTRIES];
    logic [CONF_W-1:0]  e_conf [ENTRIES];
    logic [IDX_W-1:0]   e_rank [ENTRIES];   // 0 = trained most recently

    logic             um_hit, free_hit, do_touch;
    logic [IDX_W-1:0] um_idx, free_idx, old_idx, tgt;

    // confident lookup, lowest index wins
    always_comb begin
        lk_hit   = 1'b0;
        lk_st_ip = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vld[i] && e_lip[i] == lk_ld_ip && e_off[i] == lk_off && e_conf[i] == CONF_TOP) begin
                lk_hit   = 1'b1;
                lk_st_ip = e_sip[i];
            end
        end
    end

    // update target: existing triple, else a free entry, else the oldest rank
    always_comb begin
        um_hit   = 1'b0;
        um_idx   = '0;
        free_hit = 1'b0;
        free_idx = '0;
        old_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vld[i] && e_sip[i] == upd_st_ip && e_lip[i] == upd_ld_ip && e_off[i] == upd_off) begin
                um_hit = 1'b1;
                um_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_hit = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (e_rank[i] == IDX_W'(ENTRIES - 1)) old_idx = IDX_W'(i);
        end
        tgt      = um_hit ? um_idx : (free_hit ? free_idx : old_idx);
        do_touch = (upd_kind == UPD_GOOD) || (upd_kind == UPD_BAD && um_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_sip[i]  <= '0;
                e_lip[i]  <= '0;
                e_off[i]  <= '0;
                e_conf[i] <= '0;
                e_rank[i] <= IDX_W'(i);
            end
        end else if (do_touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == tgt)            e_rank[i] <= '0;
                else if (e_rank[i] < e_rank[tgt]) e_rank[i] <= e_rank[i] + 1'b1;
            end
            if (upd_kind == UPD_BAD) begin
                e_conf[tgt] <= '0;
            end else if (um_hit) begin
                if (e_conf[tgt] != CONF_TOP) e_conf[tgt] <= e_conf[tgt] + 1'b1;
            end else begin
                vld[tgt]    <= 1'b1;
                e_sip[tgt]  <= upd_st_ip;
                e_lip[tgt]  <= upd_ld_ip;
                e_off[tgt]  <= upd_off;
                e_conf[tgt] <= CONF_W'(1);
            end
        end
    end

    AST_VALID_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld) >= $past($countones(vld))); // R8

    AST_BAD_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_kind == UPD_BAD) |=> $countones(vld) == $past($countones(vld))); // R5
endmodule

// File: rtl/mem_rename_pred.sv
module mem_rename_pred
    import mrp_pkg::*;
#(
    parameter int TBL_ENTRIES = 16,
    parameter int SB_DEPTH    = 8,
    parameter int IP_W        = 16,
    parameter int OFF_W       = 12,
    parameter int PTAG_W      = 7,
    parameter int ROB_W       = 6,
    parameter int CONF_W      = 2
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic              st_sp,
    input  logic [IP_W-1:0]   st_ip,
    input  logic [OFF_W-1:0]  st_off,
    input  logic [PTAG_W-1:0] st_ptag,
    input  logic              ld_valid,
    input  logic              ld_sp,
    input  logic [IP_W-1:0]   ld_ip,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic              vr_valid,
    input  logic              vr_bypassed,
    input  logic              vr_match,
    input  logic [IP_W-1:0]   vr_st_ip,
    input  logic [IP_W-1:0]   vr_ld_ip,
    input  logic [OFF_W-1:0]  vr_off,
    input  logic [ROB_W-1:0]  vr_rob,
    output logic              byp_valid,
    output logic [PTAG_W-1:0] byp_ptag,
    output logic              flush_valid,
    output logic [ROB_W-1:0]  flush_rob
);
    rn_state_e         state_q, state_d;
    logic [ROB_W-1:0]  rob_q;
    logic              mispredict, sb_wr, tbl_hit, sb_hit;
    logic [IP_W-1:0]   tbl_st_ip;
    logic [PTAG_W-1:0] sb_ptag;
    upd_kind_e         upd_kind;

    assign mispredict = vr_valid && vr_bypassed && !vr_match;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = mispredict ? ST_FLUSH : ST_RUN;
            ST_FLUSH: state_d = mispredict ? ST_FLUSH : ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rob_q   <= '0;
        end else begin
            state_q <= state_d;
            if (mispredict) rob_q <= vr_rob;
        end
    end

    always_comb begin
        byp_valid   = 1'b0;
        byp_ptag    = '0;
        flush_valid = 1'b0;
        flush_rob   = rob_q;
        sb_wr       = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                sb_wr     = st_valid && st_sp;
                byp_valid = ld_valid && ld_sp && tbl_hit && sb_hit;
                byp_ptag  = byp_valid ? sb_ptag : '0;
            end
            ST_FLUSH: flush_valid = 1'b1;
        endcase
        if (vr_valid && vr_match) upd_kind = UPD_GOOD;
        else if (mispredict)      upd_kind = UPD_BAD;
        else                      upd_kind = UPD_NONE;
    end

    mrp_pred_table #(
        .ENTRIES(TBL_ENTRIES), .IP_W(IP_W), .OFF_W(OFF_W), .CONF_W(CONF_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_ld_ip(ld_ip), .lk_off(ld_off),
        .lk_hit(tbl_hit), .lk_st_ip(tbl_st_ip),
        .upd_kind(upd_kind), .upd_st_ip(vr_st_ip), .upd_ld_ip(vr_ld_ip), .upd_off(vr_off)
    );

    mrp_store_buf #(
        .DEPTH(SB_DEPTH), .IP_W(IP_W), .OFF_W(OFF_W), .PTAG_W(PTAG_W)
    ) u_sbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sb_wr), .wr_ip(st_ip), .wr_off(st_off), .wr_ptag(st_ptag),
        .q_ip(tbl_st_ip), .q_off(ld_off),
        .q_hit(sb_hit), .q_ptag(sb_ptag)
    );

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(vr_valid && vr_bypassed && !vr_match)); // R5
    AST_FLUSH_ROB: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> flush_rob == $past(vr_rob)); // R5
    AST_NO_BYP_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !byp_valid); // R6
    AST_BYP_SP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        byp_valid |-> (ld_valid && ld_sp)); // R3
endmodule

// File: tb/mem_rename_pred_test.sv
module mem_rename_pred_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        st_valid, st_sp, ld_valid, ld_sp;
    logic        vr_valid, vr_bypassed, vr_match;
    logic [15:0] st_ip, ld_ip, vr_st_ip, vr_ld_ip;
    logic [11:0] st_off, ld_off, vr_off;
    logic [6:0]  st_ptag, byp_ptag;
    logic [5:0]  vr_rob, flush_rob;
    logic        byp_valid, flush_valid;

    always #4 clk = ~clk;

    mem_rename_pred uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_sp(st_sp), .st_ip(st_ip), .st_off(st_off), .st_ptag(st_ptag),
        .ld_valid(ld_valid), .ld_sp(ld_sp), .ld_ip(ld_ip), .ld_off(ld_off),
        .vr_valid(vr_valid), .vr_bypassed(vr_bypassed), .vr_match(vr_match),
        .vr_st_ip(vr_st_ip), .vr_ld_ip(vr_ld_ip), .vr_off(vr_off), .vr_rob(vr_rob),
        .byp_valid(byp_valid), .byp_ptag(byp_ptag),
        .flush_valid(flush_valid), .flush_rob(flush_rob)
    );

    typedef struct { logic [15:0] sip; logic [15:0] lip; logic [11:0] off; int conf; } pair_t;
    typedef struct { logic [15:0] ip; logic [11:0] off; logic [6:0] tag; } sto_t;
    pair_t pairs[$];   // front = most recently trained
    sto_t  stores[$];  // front = youngest
    logic  m_flush = 1'b0;
    logic [5:0] m_rob = '0;

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    localparam logic [15:0] A_SIP = 16'h0100, A_LIP = 16'h0200;
    localparam logic [11:0] A_OFF = 12'hFF8;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        st_valid = 0; st_sp = 0; st_ip = '0; st_off = '0; st_ptag = '0;
        ld_valid = 0; ld_sp = 0; ld_ip = '0; ld_off = '0;
        vr_valid = 0; vr_bypassed = 0; vr_match = 0;
        vr_st_ip = '0; vr_ld_ip = '0; vr_off = '0; vr_rob = '0;
    endtask

    task automatic expect_byp(output bit ev, output logic [6:0] et);
        logic [15:0] s;
        bit found;
        ev = 0; et = '0; found = 0; s = '0;
        if (!(ld_valid && ld_sp && !m_flush)) return;
        foreach (pairs[i])
            if (!found && pairs[i].lip == ld_ip && pairs[i].off == ld_off && pairs[i].conf == 3) begin
                found = 1; s = pairs[i].sip;
            end
        if (!found) return;
        foreach (stores[i])
            if (!ev && stores[i].ip == s && stores[i].off == ld_off) begin
                ev = 1; et = stores[i].tag;
            end
    endtask

    task automatic model_edge();
        int idx;
        pair_t e;
        if (st_valid && st_sp && !m_flush) begin
            stores.push_front('{st_ip, st_off, st_ptag});
            if (stores.size() > 8) void'(stores.pop_back());
        end
        if (vr_valid) begin
            idx = -1;
            foreach (pairs[i])
                if (pairs[i].sip == vr_st_ip && pairs[i].lip == vr_ld_ip && pairs[i].off == vr_off) idx = i;
            if (vr_match) begin
                if (idx >= 0) begin
                    e = pairs[idx];
                    e.conf = (e.conf < 3) ? e.conf + 1 : 3;
                    pairs.delete(idx);
                    pairs.push_front(e);
                end else begin
                    if (pairs.size() == 16) void'(pairs.pop_back());
                    pairs.push_front('{vr_st_ip, vr_ld_ip, vr_off, 1});
                end
            end else if (vr_bypassed && idx >= 0) begin
                e = pairs[idx];
                e.conf = 0;
                pairs.delete(idx);
                pairs.push_front(e);
            end
        end
        m_flush = vr_valid && vr_bypassed && !vr_match;
        if (m_flush) m_rob = vr_rob;
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic cyc();
        bit ev;
        logic [6:0] et;
        #1;
        expect_byp(ev, et);
        chk(byp_valid == ev, "byp_valid", int'(byp_valid), int'(ev));
        if (ev) chk(byp_ptag == et, "byp_ptag", int'(byp_ptag), int'(et));
        chk(flush_valid == m_flush, "flush_valid", int'(flush_valid), int'(m_flush));
        if (m_flush) chk(flush_rob == m_rob, "flush_rob", int'(flush_rob), int'(m_rob));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        clear_in();
    endtask

    task automatic st(input logic [15:0] ip, input logic [11:0] off, input logic [6:0] tag, input logic sp = 1);
        st_valid = 1; st_sp = sp; st_ip = ip; st_off = off; st_ptag = tag;
        cyc();
    endtask

    task automatic ld(input logic [15:0] ip, input logic [11:0] off, input logic sp = 1);
        ld_valid = 1; ld_sp = sp; ld_ip = ip; ld_off = off;
        cyc();
    endtask

    task automatic set_vfy(input logic byp, input logic mt, input logic [15:0] sip,
                           input logic [15:0] lip, input logic [11:0] off, input logic [5:0] rob);
        vr_valid = 1; vr_bypassed = byp; vr_match = mt;
        vr_st_ip = sip; vr_ld_ip = lip; vr_off = off; vr_rob = rob;
    endtask

    task automatic vfy(input logic byp, input logic mt, input logic [15:0] sip,
                       input logic [15:0] lip, input logic [11:0] off, input logic [5:0] rob);
        set_vfy(byp, mt, sip, lip, off, rob);
        cyc();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        cur_req = "R1";
        repeat (2) cyc();
        ld(A_LIP, A_OFF);

        // R4: confidence climbs 1,2,3; no bypass below 3
        cur_req = "R4";
        st(A_SIP, A_OFF, 7'd5);
        vfy(0, 1, A_SIP, A_LIP, A_OFF, 6'd1); ld(A_LIP, A_OFF);
        vfy(1, 1, A_SIP, A_LIP, A_OFF, 6'd1); ld(A_LIP, A_OFF);
        vfy(0, 1, A_SIP, A_LIP, A_OFF, 6'd1);
        cur_req = "R2"; ld(A_LIP, A_OFF);

        // R2: youngest matching store supplies the tag
        st(A_SIP, A_OFF, 7'd6); st(A_SIP, A_OFF, 7'd7); st(A_SIP, 12'hFF0, 7'd8);
        ld(A_LIP, A_OFF);

        // R3: non-stack load and store
        cur_req = "R3";
        ld(A_LIP, A_OFF, 0);
        st(A_SIP, A_OFF, 7'd9, 0);
        ld(A_LIP, A_OFF);

        // R9: same-cycle store not visible to the load
        cur_req = "R9";
        st_valid = 1; st_sp = 1; st_ip = A_SIP; st_off = A_OFF; st_ptag = 7'd11;
        ld_valid = 1; ld_sp = 1; ld_ip = A_LIP; ld_off = A_OFF;
        cyc();
        ld(A_LIP, A_OFF);

        // R9/R5: misprediction report with a load in the same cycle
        cur_req = "R5";
        set_vfy(1, 0, A_SIP, A_LIP, A_OFF, 6'd13);
        ld_valid = 1; ld_sp = 1; ld_ip = A_LIP; ld_off = A_OFF;
        cyc();
        // R6: flush cycle squashes load and store
        cur_req = "R6";
        st_valid = 1; st_sp = 1; st_ip = A_SIP; st_off = A_OFF; st_ptag = 7'd20;
        ld_valid = 1; ld_sp = 1; ld_ip = A_LIP; ld_off = A_OFF;
        cyc();
        cur_req = "R5";
        ld(A_LIP, A_OFF);
        vfy(1, 0, A_SIP, A_LIP, A_OFF, 6'd21);
        vfy(1, 0, A_SIP, A_LIP, A_OFF, 6'd22);
        cyc(); cyc();

        // R6: retrain; the store from the flush cycle was dropped
        cur_req = "R6";
        repeat (3) vfy(0, 1, A_SIP, A_LIP, A_OFF, 6'd2);
        ld(A_LIP, A_OFF);

        // R7: store buffer depth 8
        cur_req = "R7";
        st(A_SIP, A_OFF, 7'd30);
        for (int k = 0; k < 8; k++) st(16'h0300 + 16'(k), 12'h000, 7'(50 + k));
        ld(A_LIP, A_OFF);
        st(A_SIP, A_OFF, 7'd31);
        for (int k = 0; k < 7; k++) st(16'h0300 + 16'(k), 12'h000, 7'(60 + k));
        ld(A_LIP, A_OFF);

        // R10: neither bypassed nor matched changes nothing
        cur_req = "R10";
        repeat (3) vfy(0, 0, A_SIP, A_LIP, A_OFF, 6'd3);
        ld(A_LIP, A_OFF);

        // R8: replacement by training order
        cur_req = "R8";
        for (int k = 0; k < 15; k++)
            vfy(0, 1, 16'h0400 + 16'(k), 16'h0500 + 16'(k), 12'h000, 6'd4);
        vfy(0, 1, A_SIP, A_LIP, A_OFF, 6'd4);
        vfy(0, 1, 16'h0400 + 16'd15, 16'h0500 + 16'd15, 12'h000, 6'd4);
        ld(A_LIP, A_OFF);
        st(16'h0400, 12'h000, 7'd40);
        repeat (2) vfy(0, 1, 16'h0400, 16'h0500, 12'h000, 6'd5);
        ld(16'h0500, 12'h000);
        vfy(0, 1, 16'h0400, 16'h0500, 12'h000, 6'd5);
        ld(16'h0500, 12'h000);
        for (int k = 16; k < 32; k++)
            vfy(0, 1, 16'h0400 + 16'(k), 16'h0500 + 16'(k), 12'h000, 6'd6);
        ld(A_LIP, A_OFF);
        cyc();

        summary();
        $finish;
    end
endmodule